// File: doc/BRIEF.md
# Clock Supervisor Measurement Counter

This block checks an external oscillator against the internal reference clock. A free-running binary divider runs on the reference clock. One of eight divider taps is picked by software to define a counting window. During that window the block counts rising edges of the chosen external clock. The count is then handed back to the reference domain for software to read. A count of zero, or a count far from the expected ratio, shows that the oscillator is dead or off frequency.

Software programs an 8-bit control register with a source select, a window code and a run bit. Setting the run bit starts a measurement. The run bit reads 1 while the measurement is in progress and drops to 0 once the result is valid. The window opens on the first rising edge of the selected tap after the start. It closes on the next rising edge of that same tap, so it lasts exactly one tap period. The gate crosses into each oscillator domain through a two-flop synchroniser. The result is captured back only after the oscillator side has been seen to stop counting.

Top module: `clk_supervisor_counter`

## Requirements
- R1: After reset the control register reads 8'h00 and the count register reads 0.
- R2: Control bits 7, 6 and 5 always read 0. Writing 1 to them has no effect on configuration or on starting a measurement.
- R3: A write while idle loads the source select from bit 4 and the window code from bits 3:1. Both read back at the same positions.
- R4: While a measurement runs, writes do not change the source select or window code, and do not restart the measurement.
- R5: Writing 1 to bit 0 while idle starts a measurement. Bit 0 reads 1 from the cycle after that write until the result is valid, then reads 0 by itself. The busy time lies between W and 2W plus a small fixed drain, where W is the window length.
- R6: With source select 0, the count equals the number of main-oscillator rising edges inside the window, within two edges.
- R7: With source select 1, the count is taken from the sub-oscillator instead, with the same accuracy.
- R8: The count saturates at all ones (16'hFFFF) instead of wrapping.
- R9: Starting a measurement clears the count register. It reads 0 for the whole busy period.
- R10: Window code n gives a window of exactly 2^(3+2n) reference cycles. The window opens and closes on rising edges of divider bit 2+2n.
- R11: If the selected oscillator is stopped, the measurement still completes and the count reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, also drives the time-base divider |
| rst | input | 1 | Synchronous active-high reset |
| osc_main | input | 1 | Main external oscillator (source 0) |
| osc_sub | input | 1 | Sub external oscillator (source 1) |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| ctrl_rdata | output | 8 | Control register read value |
| count_rdata | output | 16 | Measured edge count |

## Verification
A stuck window state machine shows up at the port as a run bit that never clears, within two window lengths of the start. A gate opened on the wrong tap or cycle shifts the count by a factor of four per code step, so a single measurement exposes it. A broken handback either returns the previous measurement's value or returns nonzero for a stopped oscillator; both are visible at the first read after the run bit drops. A bad freeze of the configuration changes the read-back value in the cycle after the offending write.

// File: rtl/csc_pkg.sv
package csc_pkg;

    localparam int NUM_SRC  = 2;
    localparam int CODE_W   = 3;
    localparam int BIT_RUN  = 0;
    localparam int BIT_CODE = 1;
    localparam int BIT_SRC  = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_OPEN  = 2'd2,
        ST_DRAIN = 2'd3
    } win_state_e;

    typedef struct packed {
        logic              src;
        logic [CODE_W-1:0] code;
    } meas_cfg_t;

    // Divider bit whose rising edges bound the window for a given code.
    function automatic int unsigned tap_bit(logic [CODE_W-1:0] code);
        return 32'd2 + 32'd2 * 32'(code);
    endfunction

    // Window length in reference cycles for a given code.
    function automatic longint unsigned win_cycles(logic [CODE_W-1:0] code);
        return 64'd1 << (tap_bit(code) + 32'd1);
    endfunction

    function automatic meas_cfg_t decode_cfg(logic [7:0] w);
        meas_cfg_t c;
        c.src  = w[BIT_SRC];
        c.code = w[BIT_CODE +: CODE_W];
        return c;
    endfunction

    function automatic logic [7:0] encode_ctrl(meas_cfg_t c, logic busy);
        return {3'b000, c.src, c.code, busy};
    endfunction

endpackage

// File: rtl/csc_timebase.sv
module csc_timebase
    import csc_pkg::*;
#(
    parameter int DIV_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code,
    output logic              tap_rise
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] rise_pat;
    logic [DIV_W-1:0] low_mask;

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + 1'b1;
    end

    // Tap k rises when the divider's bits k..0 equal exactly 1 followed by zeros.
    always_comb begin
        rise_pat = {{(DIV_W-1){1'b0}}, 1'b1} << tap_bit(code);
        low_mask = (rise_pat << 1) - 1'b1;
        tap_rise = ((div_q & low_mask) == rise_pat);
    end

endmodule

// File: rtl/csc_window.sv
module csc_window
    import csc_pkg::*;
#(
    parameter int DIV_W  = 18,
    parameter int SETTLE = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CODE_W-1:0] code,
    input  logic              tap_rise,
    input  logic              ack,
    output logic              gate,
    output logic              busy,
    output logic              capture,
    output logic              ack_seen
);
    localparam int SET_W = $clog2(SETTLE + 1);
    localparam int LEN_W = DIV_W + 1;

    win_state_e       state_q, state_d;
    logic [SET_W-1:0] settle_q;
    logic             seen_q;
    logic             drain_done;

    assign drain_done = (settle_q == SET_W'(SETTLE)) && !ack;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)      state_d = ST_ARM;
            ST_ARM:   if (tap_rise)   state_d = ST_OPEN;
            ST_OPEN:  if (tap_rise)   state_d = ST_DRAIN;
            ST_DRAIN: if (drain_done) state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            settle_q <= '0;
            seen_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_DRAIN)             settle_q <= '0;
            else if (settle_q != SET_W'(SETTLE)) settle_q <= settle_q + 1'b1;
            if (start)                           seen_q <= 1'b0;
            else if (ack && state_q != ST_IDLE)  seen_q <= 1'b1;
        end
    end

    assign gate     = (state_q == ST_OPEN);
    assign busy     = (state_q != ST_IDLE);
    assign capture  = (state_q == ST_DRAIN) && drain_done;
    assign ack_seen = seen_q;

    // Checker: cycles spent with the gate open.
    logic [LEN_W-1:0] len_q;
    always_ff @(posedge clk) begin
        if (rst || state_q != ST_OPEN) len_q <= '0;
        else                           len_q <= len_q + 1'b1;
    end

    p_window_len_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DRAIN && $past(state_q) == ST_OPEN)
            |-> (64'(len_q) == win_cycles(code)));

    p_open_on_tap_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OPEN && $past(state_q) == ST_ARM) |-> $past(tap_rise));

    p_start_only_idle_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) != ST_IDLE && state_q == ST_ARM) |-> $past(state_q) == ST_ARM);

endmodule

// File: rtl/csc_edge_counter.sv
module csc_edge_counter #(
    parameter int CNT_W = 16
) (
    input  logic             mclk,
    input  logic             rst,
    input  logic             gate_in,
    output logic [CNT_W-1:0] cnt,
    output logic             gate_sync
);
    logic sync1_q, sync2_q, prev_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge mclk) begin
        if (rst) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            prev_q  <= 1'b0;
            cnt_q   <= '0;
        end else begin
            sync1_q <= gate_in;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
            if (sync2_q && !prev_q)  cnt_q <= {{(CNT_W-1){1'b0}}, 1'b1};
            else if (sync2_q && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt       = cnt_q;
    assign gate_sync = sync2_q;

    p_saturate_r8: assert property (@(posedge mclk) disable iff (rst)
        (cnt_q == '1 && sync2_q && prev_q) |=> cnt_q == '1);

    p_hold_closed_r6: assert property (@(posedge mclk) disable iff (rst)
        (!sync2_q) |=> $stable(cnt_q) || (sync2_q && cnt_q == CNT_W'(1)));

endmodule

// File: rtl/clk_supervisor_counter.sv
module clk_supervisor_counter
    import csc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DIV_W  = 18,
    parameter int SETTLE = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             osc_main,
    input  logic             osc_sub,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       ctrl_rdata,
    output logic [CNT_W-1:0] count_rdata
);
    meas_cfg_t          cfg_q;
    logic [CNT_W-1:0]   count_q;
    logic               start, busy, gate, capture, ack_seen, tap_rise;
    logic               ack_s1_q, ack_s2_q;
    logic [NUM_SRC-1:0] osc_vec;
    logic [NUM_SRC-1:0] gs_vec;
    logic [CNT_W-1:0]   cnt_arr [NUM_SRC];

    assign osc_vec = {osc_sub, osc_main};
    assign start   = reg_wr && reg_wdata[BIT_RUN] && !busy;

    csc_timebase #(.DIV_W(DIV_W)) tb_i (
        .clk      (clk),
        .rst      (rst),
        .code     (cfg_q.code),
        .tap_rise (tap_rise)
    );

    csc_window #(.DIV_W(DIV_W), .SETTLE(SETTLE)) win_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .code     (cfg_q.code),
        .tap_rise (tap_rise),
        .ack      (ack_s2_q),
        .gate     (gate),
        .busy     (busy),
        .capture  (capture),
        .ack_seen (ack_seen)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        csc_edge_counter #(.CNT_W(CNT_W)) cnt_i (
            .mclk      (osc_vec[g]),
            .rst       (rst),
            .gate_in   (gate && (int'(cfg_q.src) == g)),
            .cnt       (cnt_arr[g]),
            .gate_sync (gs_vec[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            count_q  <= '0;
            ack_s1_q <= 1'b0;
            ack_s2_q <= 1'b0;
        end else begin
            ack_s1_q <= gs_vec[cfg_q.src];
            ack_s2_q <= ack_s1_q;
            if (reg_wr && !busy) cfg_q <= decode_cfg(reg_wdata);
            if (start)           count_q <= '0;
            else if (capture)    count_q <= ack_seen ? cnt_arr[cfg_q.src] : '0;
        end
    end

    assign ctrl_rdata  = encode_ctrl(cfg_q, busy);
    assign count_rdata = count_q;

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
        ctrl_rdata[7:5] == 3'b000);

    p_cfg_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cfg_q));

    p_cfg_load_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(reg_wr) && !$past(busy)) |-> cfg_q == decode_cfg($past(reg_wdata)));

    p_count_clear_r9: assert property (@(posedge clk) disable iff (rst)
        busy |-> count_rdata == '0);

    p_run_start_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(reg_wr) && $past(reg_wdata[BIT_RUN]) && !$past(busy)) |-> ctrl_rdata[BIT_RUN]);

endmodule

// File: tb/clk_supervisor_counter_tb_top.sv
`timescale 1ns/1ps
module clk_supervisor_counter_tb_top;

    typedef struct packed {
        logic        sel;
        logic [2:0]  code;
        logic [15:0] lo;
        logic [15:0] hi;
    } vec_t;

    // Main oscillator 10 ns period, sub oscillator 30 ns period, reference 8 ns.
    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd0, 16'd5,   16'd8},    // R6: 64 ns window
        '{1'b0, 3'd1, 16'd24,  16'd28},   // R6: 256 ns
        '{1'b0, 3'd3, 16'd407, 16'd412},  // R6: 4096 ns
        '{1'b1, 3'd2, 16'd32,  16'd36},   // R7: 1024 ns on sub
        '{1'b1, 3'd4, 16'd544, 16'd548}   // R7: 16384 ns on sub
    };

    logic        clk = 1'b0, rst = 1'b1;
    logic        osc_main = 1'b0, osc_sub = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  ctrl_rdata;
    logic [15:0] count_rdata;
    logic        main_on = 1'b1;
    realtime     main_half = 5.0;
    int          checks = 0, errors = 0;

    always #4 clk = ~clk;
    initial forever begin #(main_half); if (main_on) osc_main = ~osc_main; end
    always #15 osc_sub = ~osc_sub;

    clk_supervisor_counter dut_i (
        .clk(clk), .rst(rst), .osc_main(osc_main), .osc_sub(osc_sub),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .ctrl_rdata(ctrl_rdata), .count_rdata(count_rdata)
    );

    task automatic check(input string req, input bit ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_ctrl(input logic [7:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 1;
        while (ctrl_rdata[0] && cyc < 200000) begin
            @(negedge clk); cyc++;
        end
    endtask

    task automatic measure(input logic sel, input logic [2:0] code,
                           output logic [15:0] cnt, output int cyc);
        longint w;
        w = 64'd1 << (3 + 2 * int'(code));
        write_ctrl({3'b000, sel, code, 1'b1});
        check("R5 run bit set", ctrl_rdata[0] == 1'b1, ctrl_rdata[0], 1);
        check("R9 count cleared", count_rdata == 16'd0, count_rdata, 0);
        wait_idle(cyc);
        cnt = count_rdata;
        check("R5 busy time", cyc >= w && cyc <= 2 * w + 40, cyc, w);
        check("R5 run bit clears", ctrl_rdata[0] == 1'b0, ctrl_rdata[0], 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] c;
        int cyc;
        repeat (8) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ctrl reset", ctrl_rdata == 8'h00, ctrl_rdata, 0);
        check("R1 count reset", count_rdata == 16'h0000, count_rdata, 0);

        // Table of measurements (R6, R7, R10)
        for (int i = 0; i < NV; i++) begin
            measure(VECS[i].sel, VECS[i].code, c, cyc);
            check(VECS[i].sel ? "R7 sub count" : "R6 main count",
                  c >= VECS[i].lo && c <= VECS[i].hi, c, VECS[i].lo);
        end

        // R2: upper bits read 0, do not start
        write_ctrl(8'hE0);
        check("R2 upper bits zero", ctrl_rdata == 8'h00, ctrl_rdata, 0);
        repeat (3) @(negedge clk);
        check("R2 no start", ctrl_rdata[0] == 1'b0, ctrl_rdata, 0);

        // R3: config loads while idle (sel bit4, code bits3:1)
        write_ctrl(8'h1A);
        check("R3 readback", ctrl_rdata == 8'h1A, ctrl_rdata, 8'h1A);
        write_ctrl(8'h00);
        check("R3 readback clear", ctrl_rdata == 8'h00, ctrl_rdata, 0);

        // R4: writes ignored while running (start code 2 on main = 8'h05)
        write_ctrl(8'h05);
        write_ctrl(8'h1F);
        check("R4 frozen config", ctrl_rdata == 8'h05, ctrl_rdata, 8'h05);
        write_ctrl(8'h00);
        check("R4 no abort", ctrl_rdata == 8'h05, ctrl_rdata, 8'h05);
        wait_idle(cyc);
        check("R4 cfg after", ctrl_rdata == 8'h04, ctrl_rdata, 8'h04);
        check("R4 R10 window kept", count_rdata >= 16'd100 && count_rdata <= 16'd105,
              count_rdata, 102);

        // R8: saturation with a 2 ns main clock and code 6
        main_half = 1.0;
        measure(1'b0, 3'd6, c, cyc);
        check("R8 saturate", c == 16'hFFFF, c, 16'hFFFF);
        main_half = 5.0;

        // R11: stopped main oscillator
        main_on = 1'b0;
        measure(1'b0, 3'd1, c, cyc);
        check("R11 dead clock", c == 16'd0, c, 0);
        main_on = 1'b1;

        // R9: fresh measurement after a nonzero result
        measure(1'b0, 3'd1, c, cyc);
        check("R9 R6 recovers", c >= 16'd24 && c <= 16'd28, c, 25);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule